// File: doc/BRIEF.md
# Tank Fill and Drain Sequencer

This block steps a tank through a fill-and-drain cycle. Each stage of the cycle is held in its own flip-flop (one bit per stage). At most one of these bits is ever set. Each stage, when it finishes, clears its own bit and sets the bit of the stage that follows. The block waits for a start button. It then opens the inlet valve and polls a level switch, alternating between a check stage and a recheck stage until the switch reports a full tank. It then closes the inlet and opens the outlet for a fixed number of clock ticks, and returns to waiting.

The stage bits are brought out so that surrounding logic can act on the current stage. The valve outputs are decoded directly from the stage bits. A stage-bit pattern that is not exactly one-hot is treated as corrupt, and the sequencer recovers to the waiting stage on the next clock edge.

Top module: `tank_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `step_bits` equals 5'b00001 (waiting) and both valve outputs are 0.
- R2: In the waiting stage (bit 0), the sequencer stays in that stage while `start_btn` is 0, whatever the value of `tank_full`. A clock edge with `start_btn` = 1 moves it to the fill stage (bit 1).
- R3: The fill stage (bit 1) always lasts exactly one cycle and then moves to the check stage (bit 2), whatever the value of `tank_full`.
- R4: The check stage (bit 2) moves to the drain stage (bit 4) when `tank_full` = 1 at the clock edge, and to the recheck stage (bit 3) otherwise.
- R5: The recheck stage (bit 3) moves to the drain stage (bit 4) when `tank_full` = 1, and back to the check stage (bit 2) otherwise.
- R6: The drain stage (bit 4) lasts exactly DRAIN_TICKS cycles and then moves to the waiting stage. `start_btn` and `tank_full` have no effect during the drain stage.
- R7: `inlet_open` is 1 exactly when the fill, check or recheck stage is active. `outlet_open` is 1 exactly when the drain stage is active.
- R8: `step_bits` always has exactly one bit set. Any other pattern in the stage register is replaced by the waiting stage at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_btn | input | 1 | Start push button |
| tank_full | input | 1 | Level switch, 1 when the tank is full |
| inlet_open | output | 1 | Inlet valve drive |
| outlet_open | output | 1 | Outlet valve drive |
| step_bits | output | 5 | One-hot stage bits: waiting, fill, check, recheck, drain (bit 0 to 4) |

## Verification
The bench builds the sequencer with DRAIN_TICKS = 4. With this value the whole drain window, and the exact cycle in which it ends, can be checked cycle by cycle in a few dozen clocks. Start is held high through the drain and on into the waiting stage. This shows that the button is ignored while the outlet is open, and that it takes effect in the first waiting cycle. Short and long polling loops between the check and recheck stages are driven. A reset is also applied in the middle of a drain.

// File: rtl/tank_seq.sv
module tank_seq #(
  parameter int DRAIN_TICKS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_btn,
  input  logic       tank_full,
  output logic       inlet_open,
  output logic       outlet_open,
  output logic [4:0] step_bits
);

  localparam int NSTEP   = 5;
  localparam int S_IDLE  = 0;
  localparam int S_FILL  = 1;
  localparam int S_CHECK = 2;
  localparam int S_RECHK = 3;
  localparam int S_DRAIN = 4;
  localparam int CW      = (DRAIN_TICKS > 1) ? $clog2(DRAIN_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DRAIN_TICKS - 1);

  logic [NSTEP-1:0] step_q, step_d;
  logic [CW-1:0]    drain_cnt;
  logic             legal, drain_last;

  assign legal      = (step_q != '0) && ((step_q & (step_q - 1'b1)) == '0);
  assign drain_last = (drain_cnt == LAST);

  always_comb begin
    step_d = '0;
    if (!legal) begin
      step_d[S_IDLE] = 1'b1;
    end else begin
      step_d[S_IDLE]  = (step_q[S_IDLE] & ~start_btn) | (step_q[S_DRAIN] & drain_last);
      step_d[S_FILL]  = step_q[S_IDLE] & start_btn;
      step_d[S_CHECK] = step_q[S_FILL] | (step_q[S_RECHK] & ~tank_full);
      step_d[S_RECHK] = step_q[S_CHECK] & ~tank_full;
      step_d[S_DRAIN] = ((step_q[S_CHECK] | step_q[S_RECHK]) & tank_full)
                      | (step_q[S_DRAIN] & ~drain_last);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q    <= NSTEP'(1) << S_IDLE;
      drain_cnt <= '0;
    end else begin
      step_q    <= step_d;
      drain_cnt <= (step_q[S_DRAIN] && !drain_last && legal) ? drain_cnt + 1'b1 : '0;
    end
  end

  assign step_bits   = step_q;
  assign inlet_open  = step_q[S_FILL] | step_q[S_CHECK] | step_q[S_RECHK];
  assign outlet_open = step_q[S_DRAIN];

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_bits) == 1);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_bits[S_IDLE] && !start_btn |=> step_bits[S_IDLE]);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_bits[S_IDLE] && start_btn |=> step_bits[S_FILL]);

  p_fill_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_bits[S_FILL] |=> step_bits[S_CHECK]);

  p_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_bits[S_CHECK] && !tank_full |=> step_bits[S_RECHK]);

  p_recheck_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_bits[S_RECHK] && !tank_full |=> step_bits[S_CHECK]);

  p_drain_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outlet_open) |-> $past(tank_full) && $past(inlet_open));

  p_drain_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outlet_open) |-> step_bits[S_IDLE]);

  p_valves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(inlet_open && outlet_open));

endmodule

// File: tb/tank_seq_bench.sv
`timescale 1ns/1ps
module tank_seq_bench;
  localparam int DT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_btn = 1'b0;
  logic tank_full = 1'b0;
  logic inlet_open, outlet_open;
  logic [4:0] step_bits;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [4:0] step; string req; } exp_t;
  exp_t q[$];

  localparam logic [4:0] IDLE  = 5'b00001;
  localparam logic [4:0] FILL  = 5'b00010;
  localparam logic [4:0] CHECK = 5'b00100;
  localparam logic [4:0] RECHK = 5'b01000;
  localparam logic [4:0] DRAIN = 5'b10000;

  always #2.5 clk = ~clk;

  tank_seq #(.DRAIN_TICKS(DT)) u_tank_seq (
    .clk(clk), .rst_n(rst_n), .start_btn(start_btn), .tank_full(tank_full),
    .inlet_open(inlet_open), .outlet_open(outlet_open), .step_bits(step_bits)
  );

  task automatic check(input string req, input logic [4:0] exp_step);
    logic exp_in, exp_out;
    exp_in  = exp_step[1] | exp_step[2] | exp_step[3];
    exp_out = exp_step[4];
    n_chk++;
    if (step_bits !== exp_step || inlet_open !== exp_in || outlet_open !== exp_out) begin
      n_bad++;
      $display("FAIL %s: step=%b in=%b out=%b expected step=%b in=%b out=%b",
               req, step_bits, inlet_open, outlet_open, exp_step, exp_in, exp_out);
    end
  endtask

  task automatic apply(input logic s, input logic f, input logic [4:0] exp_step, input string req);
    exp_t e;
    @(negedge clk);
    start_btn = s;
    tank_full = f;
    e.step = exp_step;
    e.req  = req;
    q.push_back(e);
    @(posedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, e.step);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 during reset", IDLE);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 after release", IDLE);

    apply(0, 1, IDLE, "R2 full ignored in idle");
    apply(0, 0, IDLE, "R2 hold");
    apply(0, 1, IDLE, "R2 hold");
    apply(1, 1, FILL, "R2 start");
    apply(1, 0, CHECK, "R3 fill ignores level");
    apply(1, 1, DRAIN, "R4 full at check");
    for (int i = 1; i < DT; i++) apply(1, 0, DRAIN, "R6 drain holds, inputs ignored");
    apply(1, 1, IDLE, "R6 drain ends");
    apply(1, 1, FILL, "R2 start after drain");
    apply(0, 1, CHECK, "R3 fill with full");
    apply(0, 0, RECHK, "R4 not full");
    apply(0, 0, CHECK, "R5 loop back");
    apply(0, 0, RECHK, "R4 not full again");
    apply(0, 1, DRAIN, "R5 full at recheck");
    for (int i = 1; i < DT; i++) apply(0, 1, DRAIN, "R6 drain holds");
    apply(0, 0, IDLE, "R6 drain ends");
    apply(0, 0, IDLE, "R2 hold after drain");
    apply(1, 0, FILL, "R2 start");
    apply(0, 0, CHECK, "R3");
    apply(0, 1, DRAIN, "R4 full");
    apply(0, 1, DRAIN, "R6 drain");
    @(negedge clk);
    #0.5 rst_n = 1'b0;
    @(posedge clk);
    #1 check("R1 reset mid drain", IDLE);
    @(negedge clk) rst_n = 1'b1;
    apply(0, 1, IDLE, "R2 idle after reset");
    apply(1, 0, FILL, "R2 start after reset");
    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  always @(negedge clk) if (rst_n && step_bits !== 5'b0 && !$onehot(step_bits)) begin
    n_chk++;
    n_bad++;
    $display("FAIL R8: step=%b expected one-hot", step_bits);
  end

  initial begin
    fork
      wait (done);
      begin
        #50000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule